// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits on the write path of an ECC-protected RAM, between the SEC-DED encoder and the memory write port. It receives the finished codeword, including its overall odd-parity bit, together with the write strobe. It passes the codeword to the RAM either unchanged or with one or two bits inverted, so that the single-bit correction path and the double-bit detection path on the read side can be tested on purpose.

Injection is set up through a small control register written over a plain register write port. The register holds four mutually exclusive mode enables and a 7-bit bit-position field. Two of the modes fire once and must be re-armed by clearing their enable. The other two corrupt every write while they stay enabled. A single-bit fault inverts the selected bit. A double-bit fault inverts the selected bit together with the overall parity bit, which yields an error the decoder cannot correct. The one-shot single-bit enable can only be turned on while an external enable input is high. That input is the same one that lets single-bit corrections be reported.

Top module: `ecc_fault_inject`

## Requirements
- R1: When `wr_en` is 0, or when no mode is enabled, `wr_cw_out` equals `wr_cw_in`.
- R2: The enable field `cfg_mode` uses these bits: bit 0 is one-shot single-bit, bit 1 is continuous single-bit, bit 2 is continuous double-bit, and bit 3 is one-shot double-bit. `cfg_pos` selects a codeword bit index. Legal settings are all-zero or exactly one bit set.
- R3: In one-shot single-bit mode, the first write after the enable is set has exactly bit `pos` inverted.
- R4: After a one-shot fires, later writes pass unchanged. Rewriting the enable as 1 while it is already 1 does not re-arm it. Writing 0 and then 1 re-arms it.
- R5: In continuous single-bit mode, every write has exactly bit `pos` inverted.
- R6: In continuous double-bit mode, every write has bit `pos` and the overall parity bit (index CW_W-1) inverted.
- R7: In one-shot double-bit mode, only the first write after arming has bit `pos` and the parity bit inverted.
- R8: A register write sets enable bit 0 from 0 to 1 only if `sb_rpt_en` is 1. Otherwise that bit stays 0 and the rest of the write takes effect.
- R9: A multi-hot enable value disables all injection. It sets `cfg_err` in the cycle after the write, and `cfg_err` stays high until a legal value is written.
- R10: A position of CW_W or more, or equal to the parity index, inverts no bit in any mode. A one-shot write with such a position still uses up the armed one-shot.
- R11: After reset all enables, the position and `cfg_err` are 0 and no one-shot is armed. A register write affects data writes from the next cycle on, and a data write in the same cycle uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_mode | input | 4 | Mode enables to write (see R2) |
| cfg_pos | input | 7 | Bit position to write |
| sb_rpt_en | input | 1 | External enable; gates arming of the one-shot single-bit mode |
| wr_en | input | 1 | RAM write strobe |
| wr_cw_in | input | CW_W | Encoded codeword from the ECC encoder |
| wr_cw_out | output | CW_W | Codeword to the RAM, possibly corrupted |
| cfg_err | output | 1 | Sticky flag for an illegal multi-hot enable setting |

## Verification
The assertions check every cycle that idle cycles pass data through, that no more than two bits are ever inverted, and that an illegal setting blocks all injection. They also check that a fired one-shot stays spent while its enable holds, that the external enable gates arming, and that the error flag is sticky. Only the bench scenarios can show the fire-once order: first write corrupted, rewrite of 1 ignored, re-arm through 0. The same applies to the exact bit chosen for in-range and out-of-range positions and to the timing of a register write that coincides with a data write. The bench model predicts the output codeword and the error flag on each clock.

// File: rtl/fi_pkg.sv
// Shared constants for the write-path error injector.
// Assumes the enable field is one-hot or zero when used.
package fi_pkg;
    localparam int MODE_W   = 4;
    localparam int M_OS_SB  = 0;  // one-shot single-bit
    localparam int M_CT_SB  = 1;  // continuous single-bit
    localparam int M_CT_DB  = 2;  // continuous double-bit
    localparam int M_OS_DB  = 3;  // one-shot double-bit
endpackage

// File: rtl/fi_cfg_reg.sv
// Control register: holds mode enables and bit position, gates arming of
// the one-shot single-bit enable by sb_rpt_en, flags illegal settings.
// Assumes synchronous active-low reset.
module fi_cfg_reg
    import fi_pkg::*;
#(
    parameter int POS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [POS_W-1:0]  cfg_pos,
    input  logic              sb_rpt_en,
    output logic [MODE_W-1:0] mode_eff,
    output logic [POS_W-1:0]  pos_q,
    output logic              cfg_err
);
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] mode_nxt;

    // Next enable value with the gated one-shot single-bit arming applied.
    always_comb begin
        mode_nxt = cfg_mode;
        if (cfg_mode[M_OS_SB] && !mode_q[M_OS_SB] && !sb_rpt_en)
            mode_nxt[M_OS_SB] = 1'b0;
    end

    // Register update and sticky illegal-setting flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            pos_q   <= '0;
            cfg_err <= 1'b0;
        end else if (cfg_we) begin
            mode_q  <= mode_nxt;
            pos_q   <= cfg_pos;
            cfg_err <= ($countones(mode_nxt) > 1);
        end
    end

    // Only a legal (zero or one-hot) setting reaches the injection logic.
    always_comb mode_eff = cfg_err ? '0 : mode_q;

    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !sb_rpt_en && !mode_q[M_OS_SB]) |=> !mode_q[M_OS_SB]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !cfg_we) |=> cfg_err);

    a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (mode_eff == '0));
endmodule

// File: rtl/fi_oneshot.sv
// One-shot tracker: active while enabled and not yet spent. The first write
// strobe while active spends it. Clearing the enable re-arms it.
module fi_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wr_en,
    output logic active
);
    logic spent_q;

    // Spent flag: cleared while disabled, set by the qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spent_q <= 1'b0;
        else if (!en)
            spent_q <= 1'b0;
        else if (wr_en)
            spent_q <= 1'b1;
    end

    // Armed and not yet fired.
    always_comb active = en && !spent_q;

    a_r4_stay_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_q && en) |=> spent_q);

    a_r4_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_en) |=> !active);
endmodule

// File: rtl/fi_mask_gen.sv
// Builds the inversion mask from the position and the requested fault kind.
// Positions out of range or on the parity bit give an empty mask.
// Assumes single and dbl are never both high.
module fi_mask_gen #(
    parameter int CW_W    = 39,
    parameter int POS_W   = 7,
    parameter int PAR_IDX = CW_W - 1
) (
    input  logic [POS_W-1:0] pos,
    input  logic             single,
    input  logic             dbl,
    output logic [CW_W-1:0]  mask
);
    logic [CW_W-1:0] hit;
    logic            valid;

    // One decoder compare per codeword bit.
    for (genvar i = 0; i < CW_W; i++) begin : g_hit
        assign hit[i] = (pos == POS_W'(i));
    end

    // The position is usable if it lands on a non-parity bit.
    always_comb valid = (|hit) && !hit[PAR_IDX];

    // Mask: the selected bit, plus the parity bit for a double fault.
    always_comb begin
        mask = '0;
        if (valid && (single || dbl)) mask = hit;
        if (valid && dbl)             mask[PAR_IDX] = 1'b1;
    end

    always_comb begin
        a_r10_at_most_two: assert ($countones(mask) <= 2);
    end
endmodule

// File: rtl/ecc_fault_inject.sv
// Write-path error injector between the ECC encoder and the RAM write port.
// It XORs a mask into the codeword on write strobes according to the
// control register. Assumes one clock domain and synchronous active-low reset.
module ecc_fault_inject
    import fi_pkg::*;
#(
    parameter int CW_W  = 39,
    parameter int POS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_mode,
    input  logic [POS_W-1:0]  cfg_pos,
    input  logic              sb_rpt_en,
    input  logic              wr_en,
    input  logic [CW_W-1:0]   wr_cw_in,
    output logic [CW_W-1:0]   wr_cw_out,
    output logic              cfg_err
);
    localparam int PAR_IDX = CW_W - 1;

    logic [MODE_W-1:0] mode_eff;
    logic [POS_W-1:0]  pos_q;
    logic [1:0]        os_active;
    logic              do_single;
    logic              do_dbl;
    logic [CW_W-1:0]   mask;

    fi_cfg_reg #(.POS_W(POS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_pos(cfg_pos), .sb_rpt_en(sb_rpt_en),
        .mode_eff(mode_eff), .pos_q(pos_q), .cfg_err(cfg_err)
    );

    // One tracker per one-shot mode: index 0 single-bit, index 1 double-bit.
    for (genvar k = 0; k < 2; k++) begin : g_os
        localparam int MBIT = (k == 0) ? M_OS_SB : M_OS_DB;
        fi_oneshot u_os (
            .clk(clk), .rst_n(rst_n), .en(mode_eff[MBIT]),
            .wr_en(wr_en), .active(os_active[k])
        );
    end

    // Fault kind requested for the current write.
    always_comb begin
        do_single = mode_eff[M_CT_SB] || os_active[0];
        do_dbl    = mode_eff[M_CT_DB] || os_active[1];
    end

    fi_mask_gen #(.CW_W(CW_W), .POS_W(POS_W), .PAR_IDX(PAR_IDX)) u_mask (
        .pos(pos_q), .single(do_single), .dbl(do_dbl), .mask(mask)
    );

    // Corrupt only on a write strobe.
    always_comb wr_cw_out = wr_en ? (wr_cw_in ^ mask) : wr_cw_in;

    always_comb begin
        if (rst_n && (wr_en === 1'b0))
            a_r1_idle_pass: assert (wr_cw_out == wr_cw_in);
    end

    a_r9_no_inject: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (wr_cw_out == wr_cw_in));

    a_r6_two_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_eff[M_CT_DB] && (32'(pos_q) < PAR_IDX))
            |-> ($countones(wr_cw_out ^ wr_cw_in) == 2));
endmodule

// File: tb/sim_ecc_fault_inject.sv
module sim_ecc_fault_inject;
    localparam int CW = 39;
    localparam int PW = 7;
    localparam int PAR = CW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_mode = '0;
    logic [PW-1:0] cfg_pos = '0;
    logic          sb_rpt_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_cw_in = '0;
    logic [CW-1:0] wr_cw_out;
    logic          cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R11";

    // Reference state
    logic [3:0] m_mode;
    int         m_pos;
    bit         m_err;
    bit         m_sp_s, m_sp_d;

    always #4 clk = ~clk;

    ecc_fault_inject #(.CW_W(CW), .POS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_pos(cfg_pos), .sb_rpt_en(sb_rpt_en), .wr_en(wr_en),
        .wr_cw_in(wr_cw_in), .wr_cw_out(wr_cw_out), .cfg_err(cfg_err)
    );

    function automatic logic [CW-1:0] expect_out();
        logic [CW-1:0] r;
        bit ok_pos, s, d;
        r = wr_cw_in;
        if (!wr_en || m_err) return r;
        ok_pos = (m_pos < CW) && (m_pos != PAR);
        s = m_mode[1] || (m_mode[0] && !m_sp_s);
        d = m_mode[2] || (m_mode[3] && !m_sp_d);
        if (ok_pos && (s || d)) r[m_pos] = ~r[m_pos];
        if (ok_pos && d) r[PAR] = ~r[PAR];
        return r;
    endfunction

    task automatic step(input bit we_d, input logic [CW-1:0] d,
                        input bit cwe, input logic [3:0] m, input int p,
                        input bit sb);
        logic [CW-1:0] e;
        logic [3:0]    nm;
        @(negedge clk);
        wr_en = we_d; wr_cw_in = d; cfg_we = cwe; cfg_mode = m;
        cfg_pos = PW'(p); sb_rpt_en = sb;
        #1;
        e = expect_out();
        n_chk++;
        if (wr_cw_out !== e) begin
            n_fail++;
            $display("FAIL %s: wr_cw_out=%h expected %h", tag, wr_cw_out, e);
        end
        n_chk++;
        if (cfg_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: cfg_err=%b expected %b", tag, cfg_err, m_err);
        end
        @(posedge clk);
        if (wr_en && !m_err) begin
            if (m_mode[0]) m_sp_s = 1'b1;
            if (m_mode[3]) m_sp_d = 1'b1;
        end
        if (m_err || !m_mode[0]) m_sp_s = 1'b0;
        if (m_err || !m_mode[3]) m_sp_d = 1'b0;
        if (cwe) begin
            nm = m;
            if (m[0] && !m_mode[0] && !sb) nm[0] = 1'b0;
            m_mode = nm;
            m_pos  = p;
            m_err  = ($countones(nm) > 1);
        end
    endtask

    function automatic logic [CW-1:0] pat(input int i);
        return {CW{1'b0}} | (64'h9E3779B97F4A7C15 * (i + 1));
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_mode = '0; m_pos = 0; m_err = 0; m_sp_s = 0; m_sp_d = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state: pass-through, no error
        tag = "R11";
        for (int i = 0; i < 3; i++) step(1, pat(i), 0, 4'h0, 0, 1);
        // R1 idle strobe with a continuous mode on
        tag = "R5";
        step(0, pat(3), 1, 4'b0010, 5, 1);
        for (int i = 0; i < 4; i++) step(1, pat(10 + i), 0, 4'h0, 0, 1);
        tag = "R1";
        for (int i = 0; i < 3; i++) step(0, pat(20 + i), 0, 4'h0, 0, 1);
        // R10 parity index and out of range positions
        tag = "R10";
        step(0, '0, 1, 4'b0010, PAR, 1);
        step(1, pat(30), 0, 4'h0, 0, 1);
        step(0, '0, 1, 4'b0010, 100, 1);
        step(1, pat(31), 0, 4'h0, 0, 1);
        // R6 continuous double
        tag = "R6";
        step(0, '0, 1, 4'b0100, 3, 1);
        for (int i = 0; i < 4; i++) step(1, pat(40 + i), 0, 4'h0, 0, 1);
        tag = "R10";
        step(0, '0, 1, 4'b0100, PAR, 1);
        step(1, pat(45), 0, 4'h0, 0, 1);
        // R3 / R4 one-shot single
        tag = "R3";
        step(0, '0, 1, 4'b0000, 0, 1);
        step(0, '0, 1, 4'b0001, 12, 1);
        step(1, pat(50), 0, 4'h0, 0, 1);
        tag = "R4";
        step(1, pat(51), 0, 4'h0, 0, 1);
        step(0, '0, 1, 4'b0001, 12, 1);
        step(1, pat(52), 0, 4'h0, 0, 1);
        step(0, '0, 1, 4'b0000, 12, 1);
        step(0, '0, 1, 4'b0001, 7, 1);
        step(1, pat(53), 0, 4'h0, 0, 1);
        step(1, pat(54), 0, 4'h0, 0, 1);
        // R8 arming refused without sb_rpt_en
        tag = "R8";
        step(0, '0, 1, 4'b0000, 0, 1);
        step(0, '0, 1, 4'b0001, 9, 0);
        step(1, pat(60), 0, 4'h0, 0, 0);
        step(1, pat(61), 0, 4'h0, 0, 1);
        // R7 one-shot double
        tag = "R7";
        step(0, '0, 1, 4'b1000, 20, 0);
        step(1, pat(70), 0, 4'h0, 0, 0);
        step(1, pat(71), 0, 4'h0, 0, 0);
        step(0, '0, 1, 4'b0000, 20, 0);
        step(0, '0, 1, 4'b1000, 21, 0);
        step(1, pat(72), 0, 4'h0, 0, 0);
        // R10 one-shot consumed by unusable position
        tag = "R10";
        step(0, '0, 1, 4'b0000, 0, 0);
        step(0, '0, 1, 4'b1000, 90, 0);
        step(1, pat(73), 0, 4'h0, 0, 0);
        step(0, '0, 1, 4'b1000, 4, 0);
        step(1, pat(74), 0, 4'h0, 0, 0);
        // R9 illegal setting
        tag = "R9";
        step(0, '0, 1, 4'b0110, 2, 1);
        for (int i = 0; i < 3; i++) step(1, pat(80 + i), 0, 4'h0, 0, 1);
        step(0, '0, 1, 4'b0010, 2, 1);
        step(1, pat(84), 0, 4'h0, 0, 1);
        // R2 legal settings across enables and positions
        tag = "R2";
        for (int b = 1; b < 3; b++)
            for (int p = 0; p < 40; p += 13) begin
                step(0, '0, 1, 4'(1 << b), p, 1);
                step(1, pat(90 + p + b), 0, 4'h0, 0, 1);
            end
        // R11 config write and data write in the same cycle
        tag = "R11";
        step(1, pat(100), 1, 4'b0010, 1, 1);
        step(1, pat(101), 1, 4'b0000, 1, 1);
        step(1, pat(102), 0, 4'h0, 0, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule